// File: doc/BRIEF.md
# Serial Frame Transmitter

This block sends one asynchronous serial frame on a single output line each time the surrounding logic writes a byte into it. Two frame lengths are available. The short frame carries a low start bit, eight data bits sent least significant bit first, and a high stop bit. The long frame adds an extra ninth bit, taken from a control input at the moment of the write, between the last data bit and the stop bit. A common use of the ninth bit is parity or an address marker.

Bit timing comes from a baud tick supplied from outside. A four-bit counter inside the block counts these ticks without pause from reset, and every sixteenth tick is a rollover. A frame never begins at the write itself. It begins at the first rollover that comes after the write, and every following bit boundary falls on a later rollover. A transmit-done flag goes high in the same clock cycle that the stop bit first appears on the line. The flag stays high until a clear input is pulsed.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `txd` is 1 and `tx_done_flag` is 0.
- R2: With `frame_len11` = 0 at the write, the frame is 10 bits long: a 0, then `wr_data[0]` through `wr_data[7]` in that order, then a 1.
- R3: With `frame_len11` = 1 at the write, the frame is 11 bits long. The value of `bit9_in` sampled in the write cycle is sent after `wr_data[7]` and before the stop bit of 1.
- R4: Each bit of a frame stays on `txd` for exactly 16 baud ticks, which is 16 × (clock cycles per tick) clock cycles.
- R5: The tick counter runs from reset whether or not a frame is being sent. A rollover is the clock edge on which the 16th, 32nd, 48th, … tick since reset is counted. The start bit appears on `txd` after the first rollover edge strictly later than the write edge. A write made on a rollover edge therefore waits for the next one.
- R6: `tx_done_flag` rises on the same clock edge on which the stop bit is driven onto `txd`.
- R7: `tx_done_flag` stays 1 until `flag_clr` is sampled high. After that edge it reads 0.
- R8: When `flag_clr` is high on the edge that drives a stop bit, the flag is set, not cleared.
- R9: A write made while a frame is waiting for its start rollover or is being sent is ignored. The same holds in the stop bit period. Changes to `wr_data`, `frame_len11` or `bit9_in` after an accepted write do not alter the frame.
- R10: `txd` is 1 whenever no frame is being sent, including the cycles between the write and the start rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| frame_len11 | input | 1 | 0: 10-bit frame, 1: 11-bit frame (sampled at write) |
| bit9_in | input | 1 | Ninth bit value for 11-bit frames (sampled at write) |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clears the transmit-done flag |
| txd | output | 1 | Serial line, idles high |
| tx_done_flag | output | 1 | Set when the stop bit is driven |

## Verification
Two pairs of events can land on the same clock edge. The flag clear can meet the hardware set that comes with the stop bit. A write can meet a counter rollover. The bench pulses `flag_clr` exactly on the edge that drives the stop bit and expects the flag to read 1 afterwards. It also places writes on rollover edges and one edge before them, and expects the start bit one full bit time later in the first case. Stray writes and changes to the mode and ninth-bit inputs are sent while a frame waits and while it is in flight, and the waveform is compared cycle by cycle against a model built from tick arithmetic.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  typedef enum logic {
    FRAME_SHORT = 1'b0,
    FRAME_LONG  = 1'b1
  } frame_len_e;
endpackage

// File: rtl/sftx_tick_div.sv
module sftx_tick_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic roll
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign roll = tick && (cnt_q == LAST);
endmodule

// File: rtl/sftx_seq.sv
module sftx_seq
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roll,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  frame_len_e        len_sel,
  input  logic              bit9,
  output logic              txd,
  output logic              sending,
  output logic              stop_evt
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic               pending_q;
  logic               sending_q;
  logic [FRAME_W-1:0] sh_q;
  logic [LEFT_W-1:0]  left_q;
  logic [LEFT_W-1:0]  len_q;
  logic               txd_q;
  logic               accept;

  assign accept = wr_en && !pending_q && !sending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      sending_q <= 1'b0;
      sh_q      <= '1;
      left_q    <= '0;
      len_q     <= '0;
      txd_q     <= 1'b1;
    end else begin
      if (accept) begin
        pending_q <= 1'b1;
        sh_q      <= {1'b1, (len_sel == FRAME_LONG) ? bit9 : 1'b1, wr_data, 1'b0};
        len_q     <= (len_sel == FRAME_LONG) ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
      end
      if (roll) begin
        if (sending_q) begin
          if (left_q == '0) begin
            sending_q <= 1'b0;
            txd_q     <= 1'b1;
          end else begin
            txd_q  <= sh_q[0];
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
          end
        end else if (pending_q) begin
          pending_q <= 1'b0;
          sending_q <= 1'b1;
          txd_q     <= sh_q[0];
          sh_q      <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q    <= len_q - 1'b1;
        end
      end
    end
  end

  assign txd      = txd_q;
  assign sending  = sending_q;
  assign stop_evt = roll && sending_q && (left_q == LEFT_W'(1));
endmodule

// File: rtl/sftx_flag.sv
module sftx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              frame_len11,
  input  logic              bit9_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic              txd,
  output logic              tx_done_flag
);
  logic       roll;
  logic       sending;
  logic       stop_evt;
  frame_len_e len_sel;

  assign len_sel = frame_len_e'(frame_len11);

  sftx_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (baud_tick),
    .roll (roll)
  );

  sftx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .roll     (roll),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .len_sel  (len_sel),
    .bit9     (bit9_in),
    .txd      (txd),
    .sending  (sending),
    .stop_evt (stop_evt)
  );

  sftx_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (stop_evt),
    .clr  (flag_clr),
    .flag (tx_done_flag)
  );
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic flag,
  input logic flag_clr,
  input logic roll,
  input logic sending,
  input logic stop_evt
);
  // R6
  flag_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (txd && sending));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !stop_evt) |=> !flag);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> flag);

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !sending |-> txd);

  // R4
  bit_on_rollover_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(roll));
endmodule

bind serial_frame_tx sftx_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .txd      (txd),
  .flag     (tx_done_flag),
  .flag_clr (flag_clr),
  .roll     (roll),
  .sending  (sending),
  .stop_evt (stop_evt)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
  logic       clk = 1'b0;
  logic       rst;
  logic       baud_tick;
  logic       frame_len11;
  logic       bit9_in;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       flag_clr;
  logic       txd;
  logic       tx_done_flag;

  int edge_n = 0;
  int tper   = 1;
  int total  = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  assign baud_tick = !rst && ((edge_n % tper) == tper - 1);

  serial_frame_tx dut (
    .clk          (clk),
    .rst          (rst),
    .baud_tick    (baud_tick),
    .frame_len11  (frame_len11),
    .bit9_in      (bit9_in),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .flag_clr     (flag_clr),
    .txd          (txd),
    .tx_done_flag (tx_done_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic do_reset(input int p);
    tper = p;
    rst = 1'b1; wr_en = 1'b0; flag_clr = 1'b0;
    frame_len11 = 1'b0; bit9_in = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    chk(tx_done_flag === 1'b0, "R1 flag in reset", int'(tx_done_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(tx_done_flag === 1'b0, "R1 flag after reset", int'(tx_done_flag), 0);
  endtask

  task automatic run_frame(input logic [7:0] data, input bit b9, input bit mode,
                           input int off, input bit clr_at_stop, input bit disturb);
    int per, w, r, n, stop_e, end_e, lst, j;
    logic [10:0] fb;
    bit exp_txd, exp_flag;
    string rq;
    per = 16 * tper;
    while ((edge_n % per) != off) @(negedge clk);
    wr_en = 1'b1; wr_data = data; bit9_in = b9; frame_len11 = mode;
    w = edge_n;
    @(negedge clk);
    wr_en = 1'b0;
    r = w + 1;
    while ((r % per) != per - 1) r++;
    n = mode ? 11 : 10;
    fb = mode ? {1'b1, b9, data, 1'b0} : {1'b1, 1'b1, data, 1'b0};
    stop_e = r + per * (n - 1);
    end_e  = r + per * n;
    while (edge_n <= end_e + per + 1) begin
      lst = edge_n - 1;
      if (lst < r) begin
        exp_txd = 1'b1; rq = "R5 start wait";
      end else begin
        j = (lst - r) / per;
        if (j >= n) begin
          exp_txd = 1'b1; rq = disturb ? "R9 no queued frame" : "R10 idle";
        end else begin
          exp_txd = fb[j];
          if (disturb) rq = "R9 frame kept";
          else if (((lst - r) % per) == per - 1) rq = "R4 bit length";
          else rq = mode ? "R3 long frame" : "R2 short frame";
        end
      end
      chk(txd === exp_txd, rq, int'(txd), int'(exp_txd));
      exp_flag = (lst >= stop_e);
      if (lst == stop_e && clr_at_stop) rq = "R8 set over clear";
      else if (lst > stop_e) rq = "R7 flag hold";
      else rq = "R6 flag timing";
      chk(tx_done_flag === exp_flag, rq, int'(tx_done_flag), int'(exp_flag));
      if (disturb && (edge_n == w + 1 || edge_n == r + per * 3 + 5 || edge_n == stop_e + 2)) begin
        wr_en = 1'b1; wr_data = ~data; frame_len11 = ~mode; bit9_in = ~b9;
      end else begin
        wr_en = 1'b0; wr_data = data; frame_len11 = mode; bit9_in = b9;
      end
      flag_clr = clr_at_stop && (edge_n == stop_e);
      @(negedge clk);
    end
    wr_en = 1'b0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(tx_done_flag === 1'b0, "R7 flag cleared", int'(tx_done_flag), 0);
  endtask

  initial begin
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h01; pats[5] = 8'h80;
    for (int pi = 0; pi < 2; pi++) begin
      do_reset(pi == 0 ? 1 : 3);
      for (int m = 0; m < 2; m++) begin
        for (int di = 0; di < 6; di++) begin
          int per, off;
          per = 16 * tper;
          if (di == 0) off = per - 1;
          else if (di == 1) off = 0;
          else if (di == 4) off = per - 2;
          else off = (di * 37 + m * 11) % per;
          run_frame(pats[di], bit'(di[0] ^ m[0]), bit'(m[0]), off, di == 2, di == 3 || di == 4);
        end
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule